// File: doc/BRIEF.md
# Memory Error Overflow Interrupt Controller

This block watches a stream of correctable memory error events, each tagged with a channel, a DIMM and a rank. It keeps one saturating 16-bit counter for every rank pair (ranks 0-1 and ranks 2-3) of each of two DIMMs on each of two channels, eight counters in all. When a counter climbs above a programmed threshold, the matching sticky overflow flag is set and an interrupt is raised.

A separate strobe reports loss of redundancy together with the 2-bit ID of the failing DIMM. The strobe loads a sticky field and also raises an interrupt. Software reads the flags and the field through a simple 32-bit register port. It clears them by writing zeros, and clearing a flag also restarts that rank pair's counter. A control word picks the interrupt type. SMI takes precedence over NMI, and with neither enabled no interrupt is sent.

Top module: `mei_ctrl`

## Requirements
- R1: Error events map to status bits 7:0 as bit = 4*channel + 2*dimm + rank[1]. Bit 0 is channel 0, DIMM 0, ranks 0-1. Bit 1 is channel 0, DIMM 0, ranks 2-3. Bits 2-3 are the same two rank pairs of DIMM 1. Bits 4-7 repeat this pattern for channel 1.
- R2: With threshold T, the flag of a rank pair becomes 1 on the error that takes its counter above T, which is the (T+1)-th error since reset or since the last clear. It is visible one clock after that event.
- R3: Each counter is 16 bits and saturates at 0xFFFF without wrapping. A threshold of 0xFFFF therefore never sets a flag.
- R4: Status is read and written at offset 0x50. Writing 0 to a flag bit clears that flag and resets its counter. Writing 1 leaves the flag and its counter unchanged.
- R5: If a flag is set and cleared in the same cycle, the set wins.
- R6: A redundancy-loss strobe loads its 2-bit DIMM ID into status bits 13:12. Each bit of that field is cleared by writing 0 to it and is unchanged by writing 1. A strobe in the same cycle as a write takes precedence.
- R7: The control word is at offset 0x54. Bit 15 enables SMI and bit 16 enables NMI. Both reset to 0 and read back as written.
- R8: With bit 15 set, interrupts go out on smi_o only, even when bit 16 is also set. With only bit 16 set, they go out on nmi_o. With neither bit set, no pulse is produced, but flags and the field still update.
- R9: An interrupt is a single-cycle pulse in the cycle after a flag goes from 0 to 1. An event that finds its flag already set produces no pulse.
- R10: Reserved bits read as 0, and any offset other than 0x50 and 0x54 reads as 0.
- R11: Each redundancy-loss strobe raises one interrupt pulse in the following cycle, routed as in R8.
- R12: After reset, all flags, the field, both enables and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_valid_i | input | 1 | Correctable error event |
| err_chan_i | input | 1 | Channel of the event |
| err_dimm_i | input | 1 | DIMM of the event |
| err_rank_i | input | 2 | Rank of the event |
| thresh_i | input | 16 | Overflow threshold |
| rdl_valid_i | input | 1 | Redundancy-loss strobe |
| rdl_dimm_i | input | 2 | Failing DIMM ID for the strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| smi_o | output | 1 | SMI pulse |
| nmi_o | output | 1 | NMI pulse |

## Verification
A wrong counter or a wrong flag index shows up one clock after the offending event. Either the expected bit is missing from a status read at 0x50, or the interrupt pulse is absent or appears when it should not. Saturation faults are hidden until the threshold is lowered below the saturated count. Because of that, the bench runs a long burst and then makes one more event, which must set the flag at once. Routing faults show up on the pulse one cycle after the cause, on the wrong output or on both outputs.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int unsigned NUM_CH         = 2;
  localparam int unsigned DIMMS_PER_CH   = 2;
  localparam int unsigned PAIRS_PER_DIMM = 2;
  localparam int unsigned NUM_PAIRS      = NUM_CH * DIMMS_PER_CH * PAIRS_PER_DIMM;
  localparam int unsigned IDX_W          = $clog2(NUM_PAIRS);
  localparam int unsigned DIMM_ID_W      = 2;
  localparam int unsigned FAIL_LSB       = 12;
  localparam int unsigned SMI_EN_BIT     = 15;
  localparam int unsigned NMI_EN_BIT     = 16;
  localparam int unsigned REG_W          = 32;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_SMI  = 2'd1,
    ROUTE_NMI  = 2'd2
  } route_e;

  // channel-major, then dimm, then rank pair
  function automatic logic [IDX_W-1:0] pair_index(logic ch, logic dimm, logic [1:0] rank);
    return {ch, dimm, rank[1]};
  endfunction
endpackage

// File: rtl/mei_rank_cnt.sv
module mei_rank_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             set_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = (cnt_q == CntMax) ? cnt_q : cnt_q + 1'b1;
  assign set_o   = hit_i && (cnt_inc > thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (hit_i) cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/mei_status.sv
module mei_status
  import mei_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] set_req_i,
  input  logic                 wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 rdl_valid_i,
  input  logic [DIMM_ID_W-1:0] rdl_dimm_i,
  output logic [NUM_PAIRS-1:0] flags_o,
  output logic [DIMM_ID_W-1:0] fdimm_o,
  output logic [NUM_PAIRS-1:0] rise_o,
  output logic [NUM_PAIRS-1:0] cnt_clr_o
);
  logic [NUM_PAIRS-1:0] flags_q, keep_mask;
  logic [DIMM_ID_W-1:0] fdimm_q, fdimm_keep;

  assign keep_mask  = wr_i ? wdata_i[NUM_PAIRS-1:0] : '1;
  assign fdimm_keep = wr_i ? wdata_i[FAIL_LSB +: DIMM_ID_W] : '1;
  assign rise_o     = set_req_i & ~flags_q;
  // counter restarts on a software clear that is not overridden by a set
  assign cnt_clr_o  = ~keep_mask & ~set_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      fdimm_q <= '0;
    end else begin
      flags_q <= (flags_q & keep_mask) | set_req_i;
      fdimm_q <= rdl_valid_i ? rdl_dimm_i : (fdimm_q & fdimm_keep);
    end
  end

  assign flags_o = flags_q;
  assign fdimm_o = fdimm_q;
endmodule

// File: rtl/mei_irq_route.sv
module mei_irq_route
  import mei_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic smi_en_i,
  input  logic nmi_en_i,
  output logic smi_o,
  output logic nmi_o
);
  route_e route;
  logic   smi_q, nmi_q;

  always_comb begin
    if (smi_en_i)      route = ROUTE_SMI;
    else if (nmi_en_i) route = ROUTE_NMI;
    else               route = ROUTE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      smi_q <= evt_i && (route == ROUTE_SMI);
      nmi_q <= evt_i && (route == ROUTE_NMI);
    end
  end

  assign smi_o = smi_q;
  assign nmi_o = nmi_q;
endmodule

// File: rtl/mei_ctrl.sv
module mei_ctrl
  import mei_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  STATUS_ADDR = 8'h50,
  parameter logic [7:0]  CTRL_ADDR   = 8'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic              err_chan_i,
  input  logic              err_dimm_i,
  input  logic [1:0]        err_rank_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              rdl_valid_i,
  input  logic [1:0]        rdl_dimm_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              smi_o,
  output logic              nmi_o
);
  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] CtrlAddr   = ADDR_W'(CTRL_ADDR);

  logic                 sel_status, sel_ctrl;
  logic [IDX_W-1:0]     err_idx;
  logic [NUM_PAIRS-1:0] hit, set_req, cnt_clr, rise, ovf_flags;
  logic [DIMM_ID_W-1:0] fail_dimm;
  logic                 ctl_smi_en, ctl_nmi_en, irq_evt;

  assign sel_status = (reg_addr_i == StatusAddr);
  assign sel_ctrl   = (reg_addr_i == CtrlAddr);
  assign err_idx    = pair_index(err_chan_i, err_dimm_i, err_rank_i);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign hit[g] = err_valid_i && (err_idx == IDX_W'(g));
    mei_rank_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit[g]),
      .clr_i   (cnt_clr[g]),
      .thresh_i(thresh_i),
      .set_o   (set_req[g])
    );
  end

  mei_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_req_i  (set_req),
    .wr_i       (reg_wr_i && sel_status),
    .wdata_i    (reg_wdata_i),
    .rdl_valid_i(rdl_valid_i),
    .rdl_dimm_i (rdl_dimm_i),
    .flags_o    (ovf_flags),
    .fdimm_o    (fail_dimm),
    .rise_o     (rise),
    .cnt_clr_o  (cnt_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_smi_en <= 1'b0;
      ctl_nmi_en <= 1'b0;
    end else if (reg_wr_i && sel_ctrl) begin
      ctl_smi_en <= reg_wdata_i[SMI_EN_BIT];
      ctl_nmi_en <= reg_wdata_i[NMI_EN_BIT];
    end
  end

  assign irq_evt = (|rise) || rdl_valid_i;

  mei_irq_route u_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (irq_evt),
    .smi_en_i(ctl_smi_en),
    .nmi_en_i(ctl_nmi_en),
    .smi_o   (smi_o),
    .nmi_o   (nmi_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_status) begin
      reg_rdata_o[NUM_PAIRS-1:0]            = ovf_flags;
      reg_rdata_o[FAIL_LSB +: DIMM_ID_W]    = fail_dimm;
    end else if (sel_ctrl) begin
      reg_rdata_o[SMI_EN_BIT] = ctl_smi_en;
      reg_rdata_o[NMI_EN_BIT] = ctl_nmi_en;
    end
  end
endmodule

// File: rtl/mei_ctrl_chk.sv
module mei_ctrl_chk
  import mei_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 smi_o,
  input logic                 nmi_o,
  input logic                 rdl_valid_i,
  input logic [1:0]           rdl_dimm_i,
  input logic                 reg_wr_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [NUM_PAIRS-1:0] flags,
  input logic [1:0]           fdimm,
  input logic                 smi_en,
  input logic                 nmi_en
);
  // R8: never both outputs at once
  a_r8_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smi_o && nmi_o));

  // R8: nmi only when nmi enabled and smi disabled
  a_r8_nmi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> $past(nmi_en && !smi_en));

  a_r8_smi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(smi_en));

  // R4: without a status write no flag drops
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == ADDR_W'(8'h50)) |=> ((flags & $past(flags)) == $past(flags)));

  // R6: strobe loads the field
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdl_valid_i |=> (fdimm == $past(rdl_dimm_i)));

  // R9, R11: each pulse has a cause one cycle earlier
  a_r9_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o || nmi_o) |-> ($past(rdl_valid_i) || (|(flags & ~$past(flags)))));
endmodule

bind mei_ctrl mei_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smi_o      (smi_o),
  .nmi_o      (nmi_o),
  .rdl_valid_i(rdl_valid_i),
  .rdl_dimm_i (rdl_dimm_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .flags      (ovf_flags),
  .fdimm      (fail_dimm),
  .smi_en     (ctl_smi_en),
  .nmi_en     (ctl_nmi_en)
);

// File: tb/mei_ctrl_tb_top.sv
module mei_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_valid_i = 1'b0, err_chan_i = 1'b0, err_dimm_i = 1'b0;
  logic [1:0]  err_rank_i = '0;
  logic [15:0] thresh_i = '0;
  logic        rdl_valid_i = 1'b0;
  logic [1:0]  rdl_dimm_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        smi_o, nmi_o;

  int n_run = 0, n_fail = 0;
  logic p_smi, p_nmi;

  always #2 clk_i = ~clk_i;

  mei_ctrl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  // one error event; p_smi/p_nmi hold the outputs in the following cycle
  task automatic err(logic ch, logic dm, logic [1:0] rk);
    @(negedge clk_i);
    err_valid_i = 1'b1; err_chan_i = ch; err_dimm_i = dm; err_rank_i = rk;
    @(negedge clk_i);
    err_valid_i = 1'b0;
    p_smi = smi_o; p_nmi = nmi_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h50, d); chk("R12 status after reset", d, 32'h0);
    rd(8'h54, d); chk("R12 ctrl after reset", d, 32'h0);
    chk("R12 irq outputs after reset", {30'b0, smi_o, nmi_o}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h54, 32'h0000_8000);
    rd(8'h54, d); chk("R7 smi enable readback", d, 32'h0000_8000);
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, d); chk("R10 ctrl reserved read 0", d, 32'h0001_8000);
    rd(8'h40, d); chk("R10 unmapped offset", d, 32'h0);
    wr(8'h54, 32'h0000_8000);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    thresh_i = 16'd2;
    err(1'b0, 1'b0, 2'd0); err(1'b0, 1'b0, 2'd1);
    rd(8'h50, d); chk("R2 below threshold", d, 32'h0);
    err(1'b0, 1'b0, 2'd0);
    chk("R9 pulse on rise", {31'b0, p_smi}, 32'h1);
    @(negedge clk_i);
    chk("R9 pulse one cycle", {31'b0, smi_o}, 32'h0);
    rd(8'h50, d); chk("R2 flag after T+1 errors", d, 32'h1);
    err(1'b0, 1'b0, 2'd0);
    chk("R9 no pulse when already set", {31'b0, p_smi}, 32'h0);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, d); chk("R4 write 1 keeps flag", d, 32'h1);
    wr(8'h50, 32'h0);
    rd(8'h50, d); chk("R4 write 0 clears", d, 32'h0);
    err(1'b0, 1'b0, 2'd0); err(1'b0, 1'b0, 2'd0);
    rd(8'h50, d); chk("R4 counter restarted", d, 32'h0);
    err(1'b0, 1'b0, 2'd0);
    rd(8'h50, d); chk("R4 sets again after restart", d, 32'h1);
    wr(8'h50, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    thresh_i = 16'd0;
    for (int i = 0; i < 8; i++) begin
      err(i[2], i[1], {i[0], ~i[0]});
      rd(8'h50, d); chk("R1 bit mapping", d, 32'h1 << i);
      chk("R1 pulse per pair", {31'b0, p_smi}, 32'h1);
      wr(8'h50, 32'h0);
    end
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    thresh_i = 16'd0;
    err(1'b1, 1'b1, 2'd3);
    @(negedge clk_i);
    err_valid_i = 1'b1; err_chan_i = 1'b1; err_dimm_i = 1'b1; err_rank_i = 2'd2;
    reg_addr_i = 8'h50; reg_wdata_i = 32'h0; reg_wr_i = 1'b1;
    @(negedge clk_i);
    err_valid_i = 1'b0; reg_wr_i = 1'b0;
    chk("R5 no pulse on kept flag", {31'b0, smi_o}, 32'h0);
    rd(8'h50, d); chk("R5 set beats clear", d, 32'h80);
    wr(8'h50, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    thresh_i = 16'd0;
    wr(8'h54, 32'h0001_8000);
    err(1'b0, 1'b1, 2'd0);
    chk("R8 both enabled -> smi only", {30'b0, p_smi, p_nmi}, 32'h2);
    wr(8'h54, 32'h0001_0000);
    err(1'b1, 1'b0, 2'd0);
    chk("R8 nmi only", {30'b0, p_smi, p_nmi}, 32'h1);
    wr(8'h54, 32'h0);
    err(1'b1, 1'b0, 2'd2);
    chk("R8 none enabled no pulse", {30'b0, p_smi, p_nmi}, 32'h0);
    rd(8'h50, d); chk("R8 flags still update", d, 32'h34);
    wr(8'h50, 32'h0);
    wr(8'h54, 32'h0000_8000);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    thresh_i = 16'hFFFF;
    @(negedge clk_i);
    err_valid_i = 1'b1; err_chan_i = 1'b0; err_dimm_i = 1'b1; err_rank_i = 2'd3;
    repeat (70000) @(negedge clk_i);
    err_valid_i = 1'b0;
    rd(8'h50, d); chk("R3 max threshold never sets", d, 32'h0);
    thresh_i = 16'hFFFE;
    err(1'b0, 1'b1, 2'd3);
    rd(8'h50, d); chk("R3 counter saturated not wrapped", d, 32'h8);
    wr(8'h50, 32'h0);
  endtask

  task automatic t_redundancy();
    logic [31:0] d;
    wr(8'h54, 32'h0001_0000);
    @(negedge clk_i);
    rdl_valid_i = 1'b1; rdl_dimm_i = 2'd2;
    @(negedge clk_i);
    rdl_valid_i = 1'b0;
    chk("R11 strobe raises routed pulse", {30'b0, smi_o, nmi_o}, 32'h1);
    rd(8'h50, d); chk("R6 field loaded", d, 32'h2000);
    wr(8'h50, 32'h2000);
    rd(8'h50, d); chk("R6 write 1 keeps field", d, 32'h2000);
    wr(8'h50, 32'h0);
    rd(8'h50, d); chk("R6 write 0 clears field", d, 32'h0);
    @(negedge clk_i);
    rdl_valid_i = 1'b1; rdl_dimm_i = 2'd3;
    @(negedge clk_i);
    rdl_valid_i = 1'b0;
    wr(8'h50, 32'h1000);
    rd(8'h50, d); chk("R6 per-bit clear", d, 32'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ctrl();
    t_threshold();
    t_map();
    t_set_wins();
    t_route();
    t_saturate();
    t_redundancy();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule